// File: doc/BRIEF.md
# Accumulator Microcontroller Execute Unit

This block is the execute stage of a small 8-bit accumulator machine whose instruction words are 13 bits wide. On every cycle that `issue` is high it takes one instruction word, the current accumulator value and the operand that the surrounding logic has already read from a 64-entry register file at the address the block presents on `rd_addr`. It decodes the word, computes the arithmetic, logic, rotate, swap or bit-manipulation result, and steers that result to either the accumulator or the register file. It also raises a request to skip the next instruction, or a call or jump request with its target.

The zero (Z), carry (C) and digit-carry (DC) status flags live inside the block. They update on the clock edge that ends an issued instruction, following the flag rules of each instruction. The register file, program memory, return stack and page register sit outside and connect through plain ports. All write enables, write data and requests are combinational from the current inputs, so a write takes effect in the same cycle. The flags take effect from the next edge.

Top module: `exu_core`

## Requirements
- R1: After reset `flag_z`, `flag_c` and `flag_dc` are all 0.
- R2: A register-operand word has bit 12 = 0 and bit 11 = 0. Bits 10:7 select the operation and bit 6 selects the destination (0 = accumulator, 1 = register at bits 5:0). The operations are 0100 OR, 0101 AND, 0110 XOR and 0111 ADD. OR, AND and XOR set Z from the result and leave C and DC unchanged.
- R3: ADD writes the low 8 bits of acc+operand. It sets Z when that value is zero, C to the carry out of bit 7 and DC to the carry out of bit 3.
- R4: Operation 1000 moves the operand (bit 6 = 1 writes it back to the same register), 1001 writes its complement and 1010 writes operand+1. Each sets only Z.
- R5: Operation 1011 writes operand−1 and 1111 writes operand+1, both modulo 256. Each raises `skip` when the written value is zero and changes no flag.
- R6: Operation 1100 rotates right through C (old C into bit 7, bit 0 into C). Operation 1101 rotates left through C (old C into bit 0, bit 7 into C). Both change only C.
- R7: Operation 1110 writes the operand with its two nibbles exchanged and changes no flag.
- R8: A bit word has bit 12 = 0, bit 11 = 1, a 2-bit function in bits 10:9, a bit index in bits 8:6 and the register in bits 5:0. Function 00 writes the register with that bit cleared and 01 with that bit set. Neither changes a flag.
- R9: Bit function 10 raises `skip` when the indexed operand bit is 0, and 11 when it is 1. Neither writes anything or changes a flag.
- R10: Bits 12:10 = 100 raise `call_req` with `br_target` = {`page_i`, bits 9:0} and `push_pc` = `pc_i`+1. Bits 12:10 = 101 raise `jmp_req` with the same target.
- R11: Every other word (bits 12:8 = 00000 or 00001, or bits 12:10 = 11x) writes nothing, requests nothing and changes no flag.
- R12: While `issue` is low no write enable, skip or branch request is raised and the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Instruction on `instr` executes this cycle |
| instr | input | 13 | Instruction word |
| acc_i | input | 8 | Current accumulator |
| opnd_i | input | 8 | Register-file data read at `rd_addr` |
| pc_i | input | 12 | Address of the current instruction |
| page_i | input | 2 | Current program page |
| rd_addr | output | 6 | Register-file read address |
| acc_we | output | 1 | Accumulator write enable |
| acc_wd | output | 8 | Accumulator write data |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 6 | Register-file write address |
| rf_wd | output | 8 | Register-file write data |
| skip | output | 1 | Skip the next instruction |
| call_req | output | 1 | Call request: push `push_pc`, load `br_target` |
| jmp_req | output | 1 | Jump request: load `br_target` |
| br_target | output | 12 | Branch destination |
| push_pc | output | 12 | Return address for a call |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_dc | output | 1 | Digit-carry flag |

## Verification
The only internal state is the three flags. A flag update that is wrong or missing shows at `flag_z`, `flag_c` or `flag_dc` one edge after the instruction that caused it. It also corrupts the data of the next rotate through carry in the cycle after that. Decode faults, such as a wrong destination, a wrong operation or a skip polarity inverted, show at the write and request ports in the same cycle. The bench therefore checks the combinational outputs mid-cycle and the flags just after every edge. It mixes random words over the whole 13-bit space with directed nibble-carry, wrap-to-zero and bit-index corner cases.

// File: rtl/exu_pkg.sv
package exu_pkg;

   localparam int INSTR_W = 13;
   localparam int RADDR_W = 6;
   localparam int BIDX_W  = 3;
   localparam int KFLD_W  = 10;

   typedef enum logic [4:0] {
      OP_NOP,
      OP_OR,
      OP_AND,
      OP_XOR,
      OP_ADD,
      OP_MOV,
      OP_COM,
      OP_INC,
      OP_DECSKIP,
      OP_INCSKIP,
      OP_RRC,
      OP_RLC,
      OP_SWAP,
      OP_BCLR,
      OP_BSET,
      OP_BTSTC,
      OP_BTSTS
   } exu_op_e;

   typedef struct packed {
      exu_op_e             op;
      logic                to_reg;
      logic                is_call;
      logic                is_jmp;
      logic [BIDX_W-1:0]   bit_idx;
      logic [RADDR_W-1:0]  raddr;
      logic [KFLD_W-1:0]   kfield;
   } exu_dec_t;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
   import exu_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output exu_dec_t           dec
);

   always_comb begin
      dec         = '0;
      dec.op      = OP_NOP;
      dec.raddr   = instr[RADDR_W-1:0];
      dec.kfield  = instr[KFLD_W-1:0];
      dec.bit_idx = instr[8:6];
      if (instr[12]) begin
         unique case (instr[11:10])
            2'b00:   dec.is_call = 1'b1;
            2'b01:   dec.is_jmp  = 1'b1;
            default: ;
         endcase
      end else if (instr[11]) begin
         unique case (instr[10:9])
            2'b00: begin dec.op = OP_BCLR;  dec.to_reg = 1'b1; end
            2'b01: begin dec.op = OP_BSET;  dec.to_reg = 1'b1; end
            2'b10: dec.op = OP_BTSTC;
            2'b11: dec.op = OP_BTSTS;
            default: ;
         endcase
      end else begin
         dec.to_reg = instr[6];
         unique case (instr[10:7])
            4'b0100: dec.op = OP_OR;
            4'b0101: dec.op = OP_AND;
            4'b0110: dec.op = OP_XOR;
            4'b0111: dec.op = OP_ADD;
            4'b1000: dec.op = OP_MOV;
            4'b1001: dec.op = OP_COM;
            4'b1010: dec.op = OP_INC;
            4'b1011: dec.op = OP_DECSKIP;
            4'b1100: dec.op = OP_RRC;
            4'b1101: dec.op = OP_RLC;
            4'b1110: dec.op = OP_SWAP;
            4'b1111: dec.op = OP_INCSKIP;
            default: begin dec.op = OP_NOP; dec.to_reg = 1'b0; end
         endcase
      end
   end

endmodule

// File: rtl/exu_alu.sv
module exu_alu
   import exu_pkg::*;
#(
   parameter int DW        = 8,
   parameter bit SPLIT_ADD = 1'b0
)(
   input  exu_dec_t        dec,
   input  logic [DW-1:0]   a,
   input  logic [DW-1:0]   r,
   input  logic            c_in,
   output logic [DW-1:0]   res,
   output logic            wr,
   output logic            skip,
   output logic            upd_z,
   output logic            upd_c,
   output logic            upd_dc,
   output logic            c_new,
   output logic            dc_new
);

   localparam int HALF = DW / 2;

   if ((DW % 2) != 0 || DW < 8) begin : g_bad_width
      $error("exu_alu: DW must be even and at least 8");
   end

   logic [DW-1:0] sum;
   logic          sum_c;
   logic          sum_dc;

   if (SPLIT_ADD) begin : g_split_add
      logic [HALF:0]    lo;
      logic [DW-HALF:0] hi;
      always_comb begin
         lo = {1'b0, a[HALF-1:0]} + {1'b0, r[HALF-1:0]};
         hi = {1'b0, a[DW-1:HALF]} + {1'b0, r[DW-1:HALF]} + {{(DW-HALF){1'b0}}, lo[HALF]};
      end
      assign sum    = {hi[DW-HALF-1:0], lo[HALF-1:0]};
      assign sum_c  = hi[DW-HALF];
      assign sum_dc = lo[HALF];
   end else begin : g_flat_add
      logic [DW:0] full;
      assign full   = {1'b0, a} + {1'b0, r};
      assign sum    = full[DW-1:0];
      assign sum_c  = full[DW];
      assign sum_dc = full[HALF] ^ a[HALF] ^ r[HALF];
   end

   logic [DW-1:0] mask;
   assign mask = {{(DW-1){1'b0}}, 1'b1} << dec.bit_idx;

   always_comb begin
      res    = '0;
      wr     = 1'b1;
      skip   = 1'b0;
      upd_z  = 1'b0;
      upd_c  = 1'b0;
      upd_dc = 1'b0;
      c_new  = c_in;
      dc_new = 1'b0;
      unique case (dec.op)
         OP_OR:  begin res = a | r; upd_z = 1'b1; end
         OP_AND: begin res = a & r; upd_z = 1'b1; end
         OP_XOR: begin res = a ^ r; upd_z = 1'b1; end
         OP_ADD: begin
            res = sum; upd_z = 1'b1; upd_c = 1'b1; upd_dc = 1'b1;
            c_new = sum_c; dc_new = sum_dc;
         end
         OP_MOV: begin res = r;      upd_z = 1'b1; end
         OP_COM: begin res = ~r;     upd_z = 1'b1; end
         OP_INC: begin res = r + 1'b1; upd_z = 1'b1; end
         OP_DECSKIP: begin res = r - 1'b1; skip = (res == '0); end
         OP_INCSKIP: begin res = r + 1'b1; skip = (res == '0); end
         OP_RRC: begin
            res = {c_in, r[DW-1:1]}; upd_c = 1'b1; c_new = r[0];
         end
         OP_RLC: begin
            res = {r[DW-2:0], c_in}; upd_c = 1'b1; c_new = r[DW-1];
         end
         OP_SWAP: res = {r[HALF-1:0], r[DW-1:HALF]};
         OP_BCLR: res = r & ~mask;
         OP_BSET: res = r | mask;
         OP_BTSTC: begin wr = 1'b0; skip = ~|(r & mask); end
         OP_BTSTS: begin wr = 1'b0; skip =  |(r & mask); end
         default: wr = 1'b0;
      endcase
   end

   always_comb begin
      if (dec.op == OP_BTSTC || dec.op == OP_BTSTS || dec.op == OP_NOP)
         assert_testop_nowrite_R9: assert (!wr);
   end

endmodule

// File: rtl/exu_branch.sv
module exu_branch
   import exu_pkg::*;
#(
   parameter int PCW = 12
)(
   input  exu_dec_t                dec,
   input  logic [PCW-KFLD_W-1:0]   page,
   input  logic [PCW-1:0]          pc,
   output logic                    call_req,
   output logic                    jmp_req,
   output logic [PCW-1:0]          target,
   output logic [PCW-1:0]          ret_addr
);

   if (PCW <= KFLD_W) begin : g_bad_pcw
      $error("exu_branch: PCW must exceed the 10-bit target field");
   end

   assign call_req = dec.is_call;
   assign jmp_req  = dec.is_jmp;
   assign target   = {page, dec.kfield};
   assign ret_addr = pc + {{(PCW-1){1'b0}}, 1'b1};

   always_comb begin
      assert_branch_excl_R10: assert (!(call_req && jmp_req));
   end

endmodule

// File: rtl/exu_core.sv
module exu_core
   import exu_pkg::*;
#(
   parameter int DW        = 8,
   parameter int PCW       = 12,
   parameter bit SPLIT_ADD = 1'b0
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    issue,
   input  logic [12:0]             instr,
   input  logic [DW-1:0]           acc_i,
   input  logic [DW-1:0]           opnd_i,
   input  logic [PCW-1:0]          pc_i,
   input  logic [PCW-11:0]         page_i,
   output logic [5:0]              rd_addr,
   output logic                    acc_we,
   output logic [DW-1:0]           acc_wd,
   output logic                    rf_we,
   output logic [5:0]              rf_waddr,
   output logic [DW-1:0]           rf_wd,
   output logic                    skip,
   output logic                    call_req,
   output logic                    jmp_req,
   output logic [PCW-1:0]          br_target,
   output logic [PCW-1:0]          push_pc,
   output logic                    flag_z,
   output logic                    flag_c,
   output logic                    flag_dc
);

   localparam int PAGEW = PCW - KFLD_W;

   if (PAGEW < 1) begin : g_bad_page
      $error("exu_core: page field must be at least one bit");
   end

   exu_dec_t       dec;
   logic [DW-1:0]  res;
   logic           wr, alu_skip, upd_z, upd_c, upd_dc, c_new, dc_new;
   logic           br_call, br_jmp;

   exu_decode u_dec (
      .instr (instr),
      .dec   (dec)
   );

   exu_alu #(.DW(DW), .SPLIT_ADD(SPLIT_ADD)) u_alu (
      .dec    (dec),
      .a      (acc_i),
      .r      (opnd_i),
      .c_in   (flag_c),
      .res    (res),
      .wr     (wr),
      .skip   (alu_skip),
      .upd_z  (upd_z),
      .upd_c  (upd_c),
      .upd_dc (upd_dc),
      .c_new  (c_new),
      .dc_new (dc_new)
   );

   exu_branch #(.PCW(PCW)) u_br (
      .dec      (dec),
      .page     (page_i[PAGEW-1:0]),
      .pc       (pc_i),
      .call_req (br_call),
      .jmp_req  (br_jmp),
      .target   (br_target),
      .ret_addr (push_pc)
   );

   assign rd_addr  = dec.raddr;
   assign rf_waddr = dec.raddr;
   assign acc_wd   = res;
   assign rf_wd    = res;
   assign acc_we   = issue & wr & ~dec.to_reg;
   assign rf_we    = issue & wr &  dec.to_reg;
   assign skip     = issue & alu_skip;
   assign call_req = issue & br_call;
   assign jmp_req  = issue & br_jmp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_z  <= 1'b0;
         flag_c  <= 1'b0;
         flag_dc <= 1'b0;
      end else if (issue) begin
         if (upd_z)  flag_z  <= (res == '0);
         if (upd_c)  flag_c  <= c_new;
         if (upd_dc) flag_dc <= dc_new;
      end
   end

   assert_nop_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && (instr[12:9] == 4'b0000 || instr[12:11] == 2'b11))
      |-> (!acc_we && !rf_we && !skip && !call_req && !jmp_req));

   assert_hold_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |=> $stable({flag_z, flag_c, flag_dc}));

   assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |-> !(acc_we || rf_we || skip || call_req || jmp_req));

   assert_swap_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && instr[12:7] == 6'b001110) |=> $stable({flag_z, flag_c, flag_dc}));

   assert_skip_noflags_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && skip) |=> $stable({flag_z, flag_c, flag_dc}));

   assert_rot_conly_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && instr[12:8] == 5'b00110) |=> $stable({flag_z, flag_dc}));

   assert_one_dest_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_we && rf_we));

   assert_bitop_nozflag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && instr[12:11] == 2'b01) |=> $stable({flag_z, flag_c, flag_dc}));

endmodule

// File: tb/exu_core_test.sv
module exu_core_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue = 1'b0;
   logic [12:0] instr = '0;
   logic [7:0]  acc_i = '0, opnd_i = '0;
   logic [11:0] pc_i = '0;
   logic [1:0]  page_i = '0;
   logic [5:0]  rd_addr, rf_waddr;
   logic        acc_we, rf_we, skip, call_req, jmp_req, flag_z, flag_c, flag_dc;
   logic [7:0]  acc_wd, rf_wd;
   logic [11:0] br_target, push_pc;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic mz = 1'b0, mc = 1'b0, mdc = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   exu_core uut (
      .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr),
      .acc_i(acc_i), .opnd_i(opnd_i), .pc_i(pc_i), .page_i(page_i),
      .rd_addr(rd_addr), .acc_we(acc_we), .acc_wd(acc_wd),
      .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wd(rf_wd), .skip(skip),
      .call_req(call_req), .jmp_req(jmp_req), .br_target(br_target),
      .push_pc(push_pc), .flag_z(flag_z), .flag_c(flag_c), .flag_dc(flag_dc)
   );

   function automatic string req_of(input logic [12:0] w, input logic iss);
      if (!iss) return "R12";
      if (w[12]) return (w[11] ? "R11" : "R10");
      if (w[11]) return (w[10] ? "R9" : "R8");
      case (w[10:7])
         4'b0100, 4'b0101, 4'b0110: return "R2";
         4'b0111: return "R3";
         4'b1000, 4'b1001, 4'b1010: return "R4";
         4'b1011, 4'b1111: return "R5";
         4'b1100, 4'b1101: return "R6";
         4'b1110: return "R7";
         default: return "R11";
      endcase
   endfunction

   task automatic check(input string rq, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h (instr %b)", rq, what, act, exp, instr);
      end
   endtask

   // Expected outputs and next flags derived from the requirement list.
   task automatic predict(
      input logic [12:0] w, input logic iss, input logic [7:0] a, input logic [7:0] r,
      output logic e_awe, output logic e_rwe, output logic [7:0] e_wd, output logic e_skip,
      output logic e_call, output logic e_jmp,
      output logic nz, output logic nc, output logic ndc);
      logic [8:0] s;
      logic [4:0] lo;
      logic dst;
      logic wrt;
      e_awe = 0; e_rwe = 0; e_wd = 'x; e_skip = 0; e_call = 0; e_jmp = 0;
      nz = mz; nc = mc; ndc = mdc; wrt = 0; dst = w[6];
      if (!iss) return;
      if (w[12]) begin
         e_call = (w[11:10] == 2'b00);
         e_jmp  = (w[11:10] == 2'b01);
      end else if (w[11]) begin
         case (w[10:9])
            2'b00: begin wrt = 1; dst = 1; e_wd = r & ~(8'd1 << w[8:6]); end
            2'b01: begin wrt = 1; dst = 1; e_wd = r |  (8'd1 << w[8:6]); end
            2'b10: e_skip = (r[w[8:6]] == 1'b0);
            default: e_skip = (r[w[8:6]] == 1'b1);
         endcase
      end else begin
         wrt = 1;
         case (w[10:7])
            4'b0100: begin e_wd = a | r; nz = (e_wd == 0); end
            4'b0101: begin e_wd = a & r; nz = (e_wd == 0); end
            4'b0110: begin e_wd = a ^ r; nz = (e_wd == 0); end
            4'b0111: begin
               s = a + r; lo = a[3:0] + r[3:0];
               e_wd = s[7:0]; nz = (e_wd == 0); nc = s[8]; ndc = lo[4];
            end
            4'b1000: begin e_wd = r; nz = (e_wd == 0); end
            4'b1001: begin e_wd = ~r; nz = (e_wd == 0); end
            4'b1010: begin e_wd = r + 8'd1; nz = (e_wd == 0); end
            4'b1011: begin e_wd = r - 8'd1; e_skip = (e_wd == 0); end
            4'b1111: begin e_wd = r + 8'd1; e_skip = (e_wd == 0); end
            4'b1100: begin e_wd = {mc, r[7:1]}; nc = r[0]; end
            4'b1101: begin e_wd = {r[6:0], mc}; nc = r[7]; end
            4'b1110: e_wd = {r[3:0], r[7:4]};
            default: wrt = 0;
         endcase
      end
      e_awe = wrt & ~dst;
      e_rwe = wrt & dst;
   endtask

   task automatic run(input logic [12:0] w, input logic iss, input logic [7:0] a,
                      input logic [7:0] r);
      logic e_awe, e_rwe, e_skip, e_call, e_jmp, nz, nc, ndc;
      logic [7:0] e_wd;
      string rq;
      @(negedge clk);
      instr = w; issue = iss; acc_i = a; opnd_i = r;
      pc_i = 12'($urandom); page_i = 2'($urandom);
      rq = req_of(w, iss);
      predict(w, iss, a, r, e_awe, e_rwe, e_wd, e_skip, e_call, e_jmp, nz, nc, ndc);
      #(CLK_PERIOD/4);
      check(rq, "acc_we", 16'(acc_we), 16'(e_awe));
      check(rq, "rf_we", 16'(rf_we), 16'(e_rwe));
      if (e_awe) check(rq, "acc_wd", 16'(acc_wd), 16'(e_wd));
      if (e_rwe) begin
         check(rq, "rf_wd", 16'(rf_wd), 16'(e_wd));
         check(rq, "rf_waddr", 16'(rf_waddr), 16'(w[5:0]));
      end
      check(rq, "rd_addr", 16'(rd_addr), 16'(w[5:0]));
      check(rq, "skip", 16'(skip), 16'(e_skip));
      check(rq, "call/jmp", 16'({call_req, jmp_req}), 16'({e_call, e_jmp}));
      if (e_call || e_jmp) check(rq, "target", 16'(br_target), 16'({page_i, w[9:0]}));
      if (e_call) check(rq, "push_pc", 16'(push_pc), 16'(pc_i + 12'd1));
      @(posedge clk);
      #1;
      mz = nz; mc = nc; mdc = ndc;
      check(rq, "flags", 16'({flag_z, flag_c, flag_dc}), 16'({mz, mc, mdc}));
   endtask

   function automatic logic [12:0] rand_word();
      int k = $urandom_range(0, 9);
      logic [12:0] w = 13'($urandom);
      if (k < 5) begin
         w[12:11] = 2'b00;
         w[10]    = (w[10] | w[9] | w[8] | w[7]) ? w[10] : 1'b1;
      end else if (k < 7) w[12:11] = 2'b01;
      else if (k < 8) w[12:11] = 2'b10;
      return w;
   endfunction

   function automatic logic [7:0] rand_data();
      case ($urandom_range(0, 7))
         0: return 8'h00;
         1: return 8'hFF;
         2: return 8'h01;
         default: return 8'($urandom);
      endcase
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20061));
      repeat (3) @(posedge clk);
      #1;
      // R1: flags cleared by reset
      check("R1", "reset flags", 16'({flag_z, flag_c, flag_dc}), 16'd0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1", "flags after release", 16'({flag_z, flag_c, flag_dc}), 16'd0);

      // R3: nibble carry only, then full wrap to zero
      run(13'b0_0011_11_000101, 1, 8'h0F, 8'h01);
      run(13'b0_0011_10_000101, 1, 8'hFF, 8'h01);
      run(13'b0_0011_10_000101, 1, 8'h80, 8'h80);
      // R6: rotate left then right through carry
      run(13'b0_0110_11_000010, 1, 8'h00, 8'h81);
      run(13'b0_0110_01_000010, 1, 8'h00, 8'h02);
      // R5: decrement to zero, increment wrap
      run(13'b0_0101_11_000011, 1, 8'h00, 8'h01);
      run(13'b0_0111_10_000011, 1, 8'h00, 8'hFF);
      run(13'b0_0101_10_000011, 1, 8'h00, 8'h00);
      // R7: swap keeps flags
      run(13'b0_0111_01_001000, 1, 8'h00, 8'hA5);
      // R4: move register to itself, complement to zero
      run(13'b0_0100_01_111111, 1, 8'h00, 8'h00);
      run(13'b0_0100_10_000001, 1, 8'h00, 8'hFF);
      // R8/R9: top bit index
      run(13'b0_100_111_000100, 1, 8'h00, 8'hFF);
      run(13'b0_101_111_000100, 1, 8'h00, 8'h00);
      run(13'b0_110_111_000100, 1, 8'h00, 8'h7F);
      run(13'b0_111_000_000100, 1, 8'h00, 8'h01);
      // R10: call and jump
      run(13'b1_00_1111111111, 1, 8'h00, 8'h00);
      run(13'b1_01_0000000001, 1, 8'h00, 8'h00);
      // R11: undefined encodings
      run(13'b0_0000_11_000000, 1, 8'hFF, 8'h00);
      run(13'b0_0001_10_000000, 1, 8'hFF, 8'h00);
      run(13'b1_11_0101010101, 1, 8'h00, 8'h00);
      // R12: idle add
      run(13'b0_0011_10_000000, 0, 8'hFF, 8'h01);

      for (int i = 0; i < 3000; i++) begin
         logic [12:0] w;
         w = ($urandom_range(0, 15) == 0) ? 13'($urandom) : rand_word();
         run(w, ($urandom_range(0, 9) != 0), rand_data(), rand_data());
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule